// File: doc/BRIEF.md
# Double-Precision Floating-Point Comparator

This block takes two IEEE-754 binary64 operands as raw 64-bit patterns and reports how the first relates to the second. It decodes every class straight from the bits, with no unpacking stage. The classes are signed zeros, subnormals, normals, infinities, quiet NaNs and signalling NaNs. Each accepted operation produces a one-hot four-bit condition code and two exception flags, registered one clock after the input strobe.

A mode input picks the ordered or the unordered variant of the compare. A second input says whether invalid-operation exceptions are enabled. The two variants differ only in how they raise the invalid-compare flag. The signalling-NaN flag and the condition code are the same in both. The surrounding pipeline uses the flags and the code to deliver traps and update its status register.

Top module: `fp_cmp_unit`

## Requirements
- R1: A result appears one clock after an operation is accepted. `out_valid` is high in the cycle after each clock edge that samples `in_valid` high, and low after each edge that samples it low.
- R2: Each valid result has exactly one bit of `cc` set. The encoding is cc[3] = A less than B, cc[2] = A greater than B, cc[1] = equal, cc[0] = unordered.
- R3: An operand is a NaN when its exponent field (bits 62:52) is all ones and its fraction (bits 51:0) is nonzero. If either operand is a NaN, `cc` is 4'b0001.
- R4: A NaN is signalling when fraction bit 51 is 0. `snan_flag` is set exactly when either operand is a signalling NaN, in both modes.
- R5: In ordered mode (`ordered_mode` = 1) with a NaN operand, `invc_flag` is set when `inv_en` is high or either operand is a quiet NaN (fraction bit 51 = 1). If the only NaNs are signalling and `inv_en` is low, it stays clear. It is never set without a NaN operand.
- R6: In unordered mode (`ordered_mode` = 0), `invc_flag` is always clear.
- R7: Two zeros compare equal whatever their signs.
- R8: When the signs differ and the operands are not both zero, the negative operand is the lesser.
- R9: With equal signs, the order follows magnitude, and subnormals are included without normalisation. It is direct for positive operands and mirrored for negative ones. Identical magnitudes compare equal.
- R10: Two infinities of the same sign compare equal, and an infinity is beyond any finite value of its sign.
- R11: During reset, `out_valid`, `cc`, `snan_flag` and `invc_flag` are all zero.
- R12: While `in_valid` is low, `cc`, `snan_flag` and `invc_flag` keep the last result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operands and mode are valid this cycle |
| opa | input | 64 | Operand A, raw binary64 bits |
| opb | input | 64 | Operand B, raw binary64 bits |
| ordered_mode | input | 1 | 1 = ordered compare, 0 = unordered compare |
| inv_en | input | 1 | Invalid-operation exception enable |
| out_valid | output | 1 | Result registers hold a new result |
| cc | output | 4 | One-hot condition code {lt, gt, eq, un} |
| snan_flag | output | 1 | A signalling NaN was an operand |
| invc_flag | output | 1 | Invalid-compare exception raised |

## Verification
The two exception flags can rise in the same result. Ordered compares with a signalling NaN are driven with the enable high, and also against a quiet NaN with the enable low. Each must raise both flags together. The bench judges each flag against its own rule, and also keeps a signalling-only ordered compare with the enable low, where only the signalling flag may rise. Random operand pairs, with forced NaN and infinity exponents, are checked against a reference built from real-number comparison.

// File: rtl/fp_cmp_unit.sv
module fp_cmp_unit #(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52,
  localparam int W     = 1 + EXP_W + FRAC_W,
  localparam int MAG_W = EXP_W + FRAC_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  input  logic         ordered_mode,
  input  logic         inv_en,
  output logic         out_valid,
  output logic [3:0]   cc,
  output logic         snan_flag,
  output logic         invc_flag
);

  localparam logic [3:0] CC_LT = 4'b1000;
  localparam logic [3:0] CC_GT = 4'b0100;
  localparam logic [3:0] CC_EQ = 4'b0010;
  localparam logic [3:0] CC_UN = 4'b0001;

  logic             sa, sb;
  logic [MAG_W-1:0] ma, mb;
  logic             nan_a, nan_b, qa, qb;
  logic             any_nan, any_snan;
  logic             both_zero, mag_lt, mag_eq;
  logic [3:0]       cc_n;
  logic             invc_n;

  assign sa = opa[W-1];
  assign sb = opb[W-1];
  assign ma = opa[MAG_W-1:0];
  assign mb = opb[MAG_W-1:0];

  assign nan_a = (&opa[MAG_W-1:FRAC_W]) && (|opa[FRAC_W-1:0]);
  assign nan_b = (&opb[MAG_W-1:FRAC_W]) && (|opb[FRAC_W-1:0]);
  assign qa    = nan_a && opa[FRAC_W-1];
  assign qb    = nan_b && opb[FRAC_W-1];

  assign any_nan   = nan_a || nan_b;
  assign any_snan  = (nan_a && !qa) || (nan_b && !qb);
  assign both_zero = (ma == '0) && (mb == '0);
  assign mag_lt    = ma < mb;
  assign mag_eq    = ma == mb;

  always_comb begin
    if (any_nan)        cc_n = CC_UN;
    else if (both_zero) cc_n = CC_EQ;
    else if (sa != sb)  cc_n = sa ? CC_LT : CC_GT;
    else if (mag_eq)    cc_n = CC_EQ;
    else if (mag_lt)    cc_n = sa ? CC_GT : CC_LT;
    else                cc_n = sa ? CC_LT : CC_GT;
  end

  assign invc_n = ordered_mode && any_nan && (inv_en || qa || qb);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      cc        <= '0;
      snan_flag <= 1'b0;
      invc_flag <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        cc        <= cc_n;
        snan_flag <= any_snan;
        invc_flag <= invc_n;
      end
    end
  end

endmodule

// File: rtl/fp_cmp_unit_chk.sv
module fp_cmp_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic [63:0] opa,
  input logic [63:0] opb,
  input logic        ordered_mode,
  input logic        inv_en,
  input logic        out_valid,
  input logic [3:0]  cc,
  input logic        snan_flag,
  input logic        invc_flag
);

  logic na, nb, sna, snb, za;

  assign na  = (&opa[62:52]) && (|opa[51:0]);
  assign nb  = (&opb[62:52]) && (|opb[51:0]);
  assign sna = na && !opa[51];
  assign snb = nb && !opb[51];
  assign za  = (opa[62:0] == '0) && (opb[62:0] == '0);

  assert_valid_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  assert_valid_drops_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  assert_onehot_cc_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $countones(cc) == 1);
  assert_nan_unordered_R3: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && (na || nb) |=> cc == 4'b0001);
  assert_snan_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> snan_flag == $past(sna || snb));
  assert_ordered_enabled_R5: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && ordered_mode && inv_en && (na || nb) |=> invc_flag);
  assert_unordered_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !ordered_mode |=> !invc_flag);
  assert_zeros_equal_R7: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && za |=> cc == 4'b0010);
  assert_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(cc) && $stable(snan_flag) && $stable(invc_flag));

endmodule

bind fp_cmp_unit fp_cmp_unit_chk chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opa(opa), .opb(opb),
  .ordered_mode(ordered_mode), .inv_en(inv_en), .out_valid(out_valid),
  .cc(cc), .snan_flag(snan_flag), .invc_flag(invc_flag)
);

// File: tb/fp_cmp_unit_tb_top.sv
`timescale 1ns/1ps
module fp_cmp_unit_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [63:0] opa = '0, opb = '0;
  logic        ordered_mode = 1'b0, inv_en = 1'b0;
  logic        out_valid, snan_flag, invc_flag;
  logic [3:0]  cc;
  int          checks = 0, errors = 0;

  localparam logic [63:0] PZERO = 64'h0000_0000_0000_0000;
  localparam logic [63:0] NZERO = 64'h8000_0000_0000_0000;
  localparam logic [63:0] PINF  = 64'h7FF0_0000_0000_0000;
  localparam logic [63:0] NINF  = 64'hFFF0_0000_0000_0000;
  localparam logic [63:0] QNAN  = 64'h7FF8_0000_0000_0001;
  localparam logic [63:0] SNAN  = 64'h7FF0_0000_0000_0001;
  localparam logic [63:0] ONE   = 64'h3FF0_0000_0000_0000;
  localparam logic [63:0] NONE  = 64'hBFF0_0000_0000_0000;
  localparam logic [63:0] TWO   = 64'h4000_0000_0000_0000;
  localparam logic [63:0] SUB1  = 64'h0000_0000_0000_0001;
  localparam logic [63:0] SUB2  = 64'h000F_FFFF_FFFF_FFFF;
  localparam logic [63:0] MINN  = 64'h0010_0000_0000_0000;
  localparam logic [63:0] MAXF  = 64'h7FEF_FFFF_FFFF_FFFF;

  always #2.5 clk = ~clk;

  fp_cmp_unit dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opa(opa), .opb(opb),
    .ordered_mode(ordered_mode), .inv_en(inv_en), .out_valid(out_valid),
    .cc(cc), .snan_flag(snan_flag), .invc_flag(invc_flag)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic is_nan(input logic [63:0] x);
    return (x[62:52] == 11'h7FF) && (x[51:0] != '0);
  endfunction

  task automatic run(input logic [63:0] a, input logic [63:0] b,
                     input logic ord, input logic en, input string tag);
    logic [3:0] ecc;
    logic esn, eiv;
    real ra, rb;
    esn = (is_nan(a) && !a[51]) || (is_nan(b) && !b[51]);
    if (is_nan(a) || is_nan(b)) begin
      ecc = 4'b0001;
      eiv = ord && (en || (is_nan(a) && a[51]) || (is_nan(b) && b[51]));
    end else begin
      ra = $bitstoreal(a);
      rb = $bitstoreal(b);
      ecc = (ra < rb) ? 4'b1000 : (ra > rb) ? 4'b0100 : 4'b0010;
      eiv = 1'b0;
    end
    opa = a; opb = b; ordered_mode = ord; inv_en = en; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check({tag, " R1 valid"}, {7'd0, out_valid}, 8'd1);
    check({tag, " R2 cc"}, {4'd0, cc}, {4'd0, ecc});
    check({tag, " R4 snan"}, {7'd0, snan_flag}, {7'd0, esn});
    check({tag, " R5 invc"}, {7'd0, invc_flag}, {7'd0, eiv});
  endtask

  task automatic t_reset;
    check("R11 reset out_valid", {7'd0, out_valid}, 8'd0);
    check("R11 reset cc", {4'd0, cc}, 8'd0);
    check("R11 reset flags", {6'd0, snan_flag, invc_flag}, 8'd0);
  endtask

  task automatic t_nan;
    run(QNAN, ONE, 1'b0, 1'b0, "R3 qnan unordered");
    run(ONE, SNAN, 1'b0, 1'b0, "R4 snan unordered");
    run(SNAN, PZERO, 1'b1, 1'b0, "R5 ordered snan en off");
    run(QNAN, QNAN, 1'b1, 1'b0, "R5 ordered qnan");
    run(SNAN, ONE, 1'b1, 1'b1, "R5 ordered snan en on both flags");
    run(SNAN, QNAN, 1'b1, 1'b0, "R5 snan and qnan both flags");
    run(SNAN, SNAN, 1'b0, 1'b1, "R6 unordered never invc");
    run(64'hFFFF_FFFF_FFFF_FFFF, NINF, 1'b1, 1'b0, "R3 negative qnan");
    run(ONE, TWO, 1'b1, 1'b1, "R5 ordered no nan");
  endtask

  task automatic t_zero_sign;
    run(PZERO, NZERO, 1'b0, 1'b0, "R7 +0 -0");
    run(NZERO, PZERO, 1'b1, 1'b0, "R7 -0 +0");
    run(NZERO, SUB1, 1'b0, 1'b0, "R8 -0 vs +sub");
    run(NONE, ONE, 1'b0, 1'b0, "R8 -1 vs 1");
    run(TWO, NONE, 1'b0, 1'b0, "R8 2 vs -1");
    run(PZERO, {1'b1, SUB1[62:0]}, 1'b0, 1'b0, "R8 +0 vs -sub");
  endtask

  task automatic t_magnitude;
    run(ONE, TWO, 1'b0, 1'b0, "R9 1<2");
    run({1'b1, ONE[62:0]}, {1'b1, TWO[62:0]}, 1'b0, 1'b0, "R9 -1>-2");
    run(SUB1, SUB2, 1'b0, 1'b0, "R9 subnormals");
    run(SUB2, MINN, 1'b0, 1'b0, "R9 sub vs min normal");
    run({1'b1, SUB2[62:0]}, {1'b1, SUB1[62:0]}, 1'b0, 1'b0, "R9 neg subnormals");
    run(TWO, TWO, 1'b1, 1'b0, "R9 identical");
    run(PZERO, SUB1, 1'b0, 1'b0, "R9 zero below sub");
  endtask

  task automatic t_inf;
    run(PINF, PINF, 1'b0, 1'b0, "R10 +inf == +inf");
    run(NINF, NINF, 1'b1, 1'b1, "R10 -inf == -inf");
    run(MAXF, PINF, 1'b0, 1'b0, "R10 max < inf");
    run(NINF, {1'b1, MAXF[62:0]}, 1'b0, 1'b0, "R10 -inf < -max");
    run(NINF, PINF, 1'b0, 1'b0, "R10 -inf < +inf");
  endtask

  task automatic t_hold;
    run(NONE, ONE, 1'b1, 1'b0, "R12 setup");
    opa = SNAN; opb = QNAN; ordered_mode = 1'b1; inv_en = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 idle valid low", {7'd0, out_valid}, 8'd0);
    check("R12 cc held", {4'd0, cc}, 8'h08);
    check("R12 flags held", {6'd0, snan_flag, invc_flag}, 8'd0);
  endtask

  task automatic t_random;
    for (int i = 0; i < 400; i++) begin
      logic [63:0] a, b;
      a = {$urandom, $urandom};
      b = {$urandom, $urandom};
      case (i % 8)
        1: b = {~a[63], a[62:0]};
        2: b = a;
        3: a[62:52] = 11'h7FF;
        4: begin a[62:52] = 11'h000; b[62:52] = 11'h000; b[63] = a[63]; end
        5: b[63] = a[63];
        default: ;
      endcase
      run(a, b, i[3], i[4], "R9 random");
    end
  endtask

  initial begin
    #2_000_000;
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_nan();
    t_zero_sign();
    t_magnitude();
    t_inf();
    t_hold();
    t_random();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule